// File: doc/BRIEF.md
# Stereo Bitstream Sinc-Cubed Decimator

This block is the first decimation stage behind a pair of one-bit sigma-delta modulators. It takes a left and a right bitstream at 128 times the audio word rate and filters each one with a third-order sinc lowpass kernel. It keeps one result in every sixteen, so each channel delivers a signed multi-bit word at 8 times the word rate. Later half-band stages take these words and bring them down to the final rate.

A bit of 1 counts as +1 and a bit of 0 counts as -1. The kernel is the convolution of three boxcars, each 22 samples long, which gives 64 symmetric integer taps that sum to 10648. Input samples arrive when `smp_en` is high, with one bit per channel. When a result is ready, `dec_valid` pulses high and both channel words are updated together.

Sequencing is a two-state machine. FILL is entered on reset and counts the accepted samples until the 64-tap window holds only real data. The FILL to RUN transition happens on the 64th accepted sample. RUN then emits one result per group of sixteen samples. It stays in RUN until the next reset, and reset is the only transition back to FILL.

Top module: `sinc3_decim16`

## Requirements
- R1: Input bit 1 contributes +1 and bit 0 contributes -1. A window of all ones gives +10648, a window of all zeros gives -10648, and a window that is mostly ones gives a positive word.
- R2: Each output word equals the sum over k = 0..63 of h[k]·s[n-k], where s is the ±1 input sequence and h is the convolution of three length-22 all-ones sequences. A window that alternates 1,0,1,0 therefore gives exactly 0.
- R3: After the FILL phase, `dec_valid` is a single-cycle pulse. It rises in the cycle after every 16th accepted sample and is never high in a cycle that does not follow an accepted sample.
- R4: After reset, `dec_valid` stays low for the first 63 accepted samples. The first pulse follows the 64th accepted sample (the FILL to RUN transition).
- R5: The left and right channels are filtered independently. Each output word depends only on its own input bit.
- R6: While `smp_en` is low, the input bits are ignored. They change no history, no counter and no output.
- R7: A synchronous reset clears both output words to 0, clears `dec_valid`, clears the history and restarts the FILL phase.
- R8: Output words never overflow. Every emitted word lies within ±10648 and is represented in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Accept one input bit per channel this cycle (128fs strobe) |
| bit_l | input | 1 | Left modulator bit |
| bit_r | input | 1 | Right modulator bit |
| dec_valid | output | 1 | One-cycle pulse when new words are present |
| word_l | output | 15 | Left filtered word, signed |
| word_r | output | 15 | Right filtered word, signed |

## Verification
The assertions check the following on every cycle:
- The valid pulse lasts exactly one cycle and always follows an accepted sample.
- The RUN state, once reached, holds until reset.
- The history does not move while the strobe is low.
- Emitted words stay within ±10648.

Only the bench scenarios can show the remaining behaviour:
- The exact word values against an independently built kernel.
- The 64-sample fill delay after reset, including after a reset in the middle of a run.
- The independence of the two channels.
- Sign correctness for constant, alternating and biased bitstreams.

// File: rtl/sinc3_decim_pkg.sv
package sinc3_decim_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } dec_state_e;

    // Tap n of three length-`box` boxcars convolved: number of (a,b,c)
    // triples in [0,box) whose sum equals n.
    function automatic int sinc3_tap(input int n, input int box);
        int cnt;
        int c;
        cnt = 0;
        for (int a = 0; a < box; a++) begin
            for (int b = 0; b < box; b++) begin
                c = n - a - b;
                if (c >= 0 && c < box) cnt++;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/sinc3_tap_line.sv
module sinc3_tap_line #(
    parameter int TAPS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            din,
    output logic [TAPS-1:0] window
);
    localparam int HW = TAPS - 1;

    logic [HW-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HW-2:0], din};
        end
    end

    // window[0] is the live sample; window[k] is k samples older
    assign window = {hist_q, din};

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/sinc3_pair_sum.sv
module sinc3_pair_sum
    import sinc3_decim_pkg::*;
#(
    parameter int BOX   = 22,
    parameter int TAPS  = 3 * BOX - 2,
    parameter int OUT_W = 15
) (
    input  logic [TAPS-1:0]          window,
    output logic signed [OUT_W-1:0]  acc
);
    localparam int NPAIR = TAPS / 2;
    localparam int NTERM = NPAIR + (TAPS % 2);

    logic signed [OUT_W-1:0] term [NTERM];

    genvar k;
    generate
        for (k = 0; k < NPAIR; k++) begin : g_pair
            localparam int H2 = 2 * sinc3_tap(k, BOX);
            logic lo_b, hi_b;
            assign lo_b = window[k];
            assign hi_b = window[TAPS-1-k];
            // (+/-1) + (+/-1) is one of -2, 0, +2
            assign term[k] = (lo_b & hi_b)   ?  OUT_W'(H2) :
                             (!lo_b && !hi_b) ? -OUT_W'(H2) : '0;
        end
        if (TAPS % 2 == 1) begin : g_mid
            localparam int HM = sinc3_tap(NPAIR, BOX);
            assign term[NPAIR] = window[NPAIR] ? OUT_W'(HM) : -OUT_W'(HM);
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTERM; i++) begin
            acc = acc + term[i];
        end
    end

endmodule

// File: rtl/sinc3_phase_fsm.sv
module sinc3_phase_fsm
    import sinc3_decim_pkg::*;
#(
    parameter int TAPS  = 64,
    parameter int DECIM = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    output logic emit
);
    localparam int CW = $clog2(TAPS + 1);
    localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0] FILL_LAST  = CW'(TAPS - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(DECIM - 1);

    dec_state_e    state_q, state_d;
    logic [CW-1:0] fill_q;
    logic [PW-1:0] phase_q;
    logic          fill_done;
    logic          group_end;

    assign fill_done = (fill_q == FILL_LAST);
    assign group_end = (phase_q == PHASE_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FILL;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (smp_en && fill_done) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        emit = 1'b0;
        unique case (state_q)
            ST_FILL: emit = smp_en && group_end && fill_done;
            ST_RUN:  emit = smp_en && group_end;
        endcase
    end

    // sample and phase counters
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            phase_q <= '0;
        end else if (smp_en) begin
            phase_q <= group_end ? '0 : phase_q + 1'b1;
            if (state_q == ST_FILL) fill_q <= fill_q + 1'b1;
        end
    end

    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    assert_emit_needs_fill_R4: assert property (@(posedge clk) disable iff (rst)
        emit |=> (state_q == ST_RUN));

endmodule

// File: rtl/sinc3_decim16.sv
module sinc3_decim16 #(
    parameter int BOX   = 22,
    parameter int DECIM = 16,
    parameter int TAPS  = 3 * BOX - 2,
    parameter int OUT_W = $clog2(BOX * BOX * BOX + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    input  logic                    bit_l,
    input  logic                    bit_r,
    output logic                    dec_valid,
    output logic signed [OUT_W-1:0] word_l,
    output logic signed [OUT_W-1:0] word_r
);
    localparam int NCH = 2;
    localparam int LIM = BOX * BOX * BOX;

    logic                    ch_bit [NCH];
    logic signed [OUT_W-1:0] ch_acc [NCH];
    logic                    emit;

    assign ch_bit[0] = bit_l;
    assign ch_bit[1] = bit_r;

    sinc3_phase_fsm #(.TAPS(TAPS), .DECIM(DECIM)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .smp_en (smp_en),
        .emit   (emit)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [TAPS-1:0] win;
            sinc3_tap_line #(.TAPS(TAPS)) u_line (
                .clk      (clk),
                .rst      (rst),
                .shift_en (smp_en),
                .din      (ch_bit[c]),
                .window   (win)
            );
            sinc3_pair_sum #(.BOX(BOX), .TAPS(TAPS), .OUT_W(OUT_W)) u_sum (
                .window (win),
                .acc    (ch_acc[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            word_l    <= '0;
            word_r    <= '0;
        end else begin
            dec_valid <= emit;
            if (emit) begin
                word_l <= ch_acc[0];
                word_r <= ch_acc[1];
            end
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    assert_valid_after_sample_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(smp_en));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (int'(word_l) <= LIM && int'(word_l) >= -LIM &&
                       int'(word_r) <= LIM && int'(word_r) >= -LIM));

endmodule

// File: tb/sinc3_decim16_tb_top.sv
`timescale 1ns/1ps
module sinc3_decim16_tb_top;
    localparam int BOX   = 22;
    localparam int TAPS  = 3 * BOX - 2;
    localparam int DECIM = 16;
    localparam int OUT_W = 15;
    localparam int NV    = 6;
    // {groups[7:0], left pattern[15:0], right pattern[15:0]}, bit i sent i-th
    localparam logic [39:0] VEC [NV] = '{
        {8'd5, 16'hFFFF, 16'h0000},
        {8'd5, 16'h0000, 16'hFFFF},
        {8'd5, 16'hAAAA, 16'h5555},
        {8'd4, 16'h00FF, 16'hF0F0},
        {8'd4, 16'h1234, 16'hFEDC},
        {8'd3, 16'h7FFF, 16'h8001}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0, bit_l = 1'b0, bit_r = 1'b0;
    logic dec_valid;
    logic signed [OUT_W-1:0] word_l, word_r;

    int n_checks = 0, n_errors = 0;
    int coef [TAPS];
    bit hl [TAPS], hr [TAPS];
    int n_acc = 0;
    bit exp_v = 0;
    int exp_l = 0, exp_r = 0;
    bit armed = 0;
    string cur_req = "R7";

    always #2.5 clk = ~clk;

    sinc3_decim16 dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .bit_l(bit_l), .bit_r(bit_r),
        .dec_valid(dec_valid), .word_l(word_l), .word_r(word_r)
    );

    task automatic chk(input string tag, input string what, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    function automatic int model(input bit ch);
        int s = 0;
        for (int k = 0; k < TAPS; k++) begin
            if (ch ? hr[k] : hl[k]) s += coef[k];
            else                    s -= coef[k];
        end
        return s;
    endfunction

    // Check what the previous step predicted, then drive the next cycle.
    task automatic step(input logic r, input logic e, input logic bl, input logic br);
        @(negedge clk);
        if (armed) begin
            chk(cur_req, "dec_valid", int'(dec_valid), int'(exp_v));
            chk(cur_req, "word_l", int'(word_l), exp_l);
            chk(cur_req, "word_r", int'(word_r), exp_r);
        end
        rst = r; smp_en = e; bit_l = bl; bit_r = br;
        exp_v = 0;
        if (r) begin
            for (int k = 0; k < TAPS; k++) begin hl[k] = 0; hr[k] = 0; end
            n_acc = 0; exp_l = 0; exp_r = 0;
        end else if (e) begin
            for (int k = TAPS - 1; k > 0; k--) begin hl[k] = hl[k-1]; hr[k] = hr[k-1]; end
            hl[0] = bl; hr[0] = br;
            n_acc++;
            if (n_acc >= TAPS && n_acc % DECIM == 0) begin
                exp_v = 1; exp_l = model(0); exp_r = model(1);
            end
        end
        armed = 1;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        int box [BOX];
        int c2 [2*BOX-1];
        int tot;
        // independent kernel: explicit boxcar convolution
        for (int i = 0; i < BOX; i++) box[i] = 1;
        for (int i = 0; i < 2*BOX-1; i++) c2[i] = 0;
        for (int i = 0; i < BOX; i++) for (int j = 0; j < BOX; j++) c2[i+j] += box[i] * box[j];
        for (int i = 0; i < TAPS; i++) coef[i] = 0;
        for (int i = 0; i < 2*BOX-1; i++) for (int j = 0; j < BOX; j++) coef[i+j] += c2[i] * box[j];
        tot = 0;
        for (int i = 0; i < TAPS; i++) tot += coef[i];
        chk("R2", "kernel sum", tot, 10648);

        // R7 reset state
        cur_req = "R7";
        step(1, 0, 0, 0);
        step(1, 0, 1, 1);
        step(0, 0, 0, 0);

        // vector table: R2, R3, R4, R5 against the model
        cur_req = "R2";
        for (int v = 0; v < NV; v++) begin
            for (int g = 0; g < int'(VEC[v][39:32]); g++) begin
                for (int i = 0; i < DECIM; i++) step(0, 1, VEC[v][16+i], VEC[v][i]);
                if (g % 2 == 1) step(0, 0, 1, 0);
            end
        end

        // R7 mid-run reset, then R4 fill delay with R1/R5 constant inputs
        cur_req = "R7";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        chk("R7", "word_l after reset", int'(word_l), 0);
        cur_req = "R4";
        for (int i = 0; i < TAPS; i++) step(0, 1, 1, 0);
        step(0, 0, 0, 0);
        chk("R1", "all ones", int'(word_l), 10648);
        chk("R5", "all zeros beside all ones", int'(word_r), -10648);

        // R6 bits toggled while strobe low must not move anything
        cur_req = "R6";
        for (int i = 0; i < 12; i++) step(0, 0, i[0], ~i[0]);
        for (int i = 0; i < DECIM; i++) step(0, 1, 1, 0);
        step(0, 0, 0, 0);
        chk("R6", "held history", int'(word_l), 10648);
        chk("R6", "held history right", int'(word_r), -10648);

        // R2 alternating window gives zero; R1 biased stream is positive
        cur_req = "R2";
        step(1, 0, 0, 0);
        for (int i = 0; i < TAPS; i++) step(0, 1, i[0], (i % 4) != 0);
        step(0, 0, 0, 0);
        chk("R2", "alternating", int'(word_l), 0);
        n_checks++;
        if (int'(word_r) <= 0) begin
            n_errors++;
            $display("FAIL R1 biased ones: got %0d expected >0", int'(word_r));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule